// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single output line. A word written through the parallel port first lands in a one-word holding register. From there it moves into a frame shifter, which sends a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts one period of an external one-cycle baud tick. The data field is eight bits wide, or nine bits when the nine-bit mode input is set. The ninth bit is captured from its own write input, together with the data.

The holding register and the shifter are separate, so software can load the next word while the current frame is still going out. When a word is waiting as a stop bit ends, its start bit follows on the same tick, and the frames run with no idle bit between them. Two flags report the buffer state: one shows that the holding register can take a word, the other that no frame is being sent or pending. A port enable makes the output pin driven. A transmit enable runs the transmitter; clearing it cancels all activity.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset the line is high, `hold_empty` and `shift_empty` are both high, and `tx_oe` equals `port_en`.
- R2: A write accepted at a clock edge makes `hold_empty` low after that edge. If the shifter is idle, the word moves into it at the next edge, where `hold_empty` returns high and `shift_empty` goes low.
- R3: A frame is one low start bit, then the data bits in order from bit 0 upward, then one high stop bit. The line changes only at edges where `baud_tick` is high. The start bit begins at the first tick after the word is loaded.
- R4: With `nine_bit_mode` high, the frame carries nine data bits, and the ninth is the `wr_bit9` value captured at the write. With it low, the frame carries eight data bits and `wr_bit9` has no effect on the line.
- R5: If a word is held when the stop bit ends, the next start bit begins at that same tick, with zero idle bit periods between the two frames.
- R6: `shift_empty` is low from the load of a word until the tick that ends the last stop bit when no word is pending, and the line is high whenever `shift_empty` is high.
- R7: `tx_oe` follows `port_en` whether or not `tx_en` is set. While `tx_en` is low, the line stays high.
- R8: If `port_en` or `tx_en` is low at an edge, then after that edge any frame in progress is dropped, the line is high, and both flags are high.
- R9: A write presented while `port_en` or `tx_en` is low is ignored: both flags stay high and no frame is sent.

Wr_valid pulses while the holding register is already full are not covered by any requirement. The stimulus writes only when `hold_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_en | input | 1 | Serial port enable; makes the output pin driven |
| tx_en | input | 1 | Transmitter enable; low aborts and clears |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| nine_bit_mode | input | 1 | High selects a nine-bit data field |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word to send |
| wr_bit9 | input | 1 | Ninth data bit, used in nine-bit mode |
| tx_line | output | 1 | Serial output line, idle high |
| tx_oe | output | 1 | Output driver enable for the line |
| hold_empty | output | 1 | Holding register can accept a word |
| shift_empty | output | 1 | No frame in progress or pending |

## Verification
The properties assume three things about the inputs: `baud_tick` is a single-cycle pulse, `wr_valid` is raised only while `hold_empty` is high, and `nine_bit_mode` changes only while both flags are high. The stimulus follows all three. The bench makes the tick itself at a fixed divide of the clock. It issues each write only after seeing `hold_empty` high at a falling edge, and it switches between eight-bit and nine-bit sweeps only after waiting for both flags. When it aborts a frame, it stops its line decoder before dropping `tx_en`, so the cut-short frame is never compared.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PEND  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/ser_tx_rst_sync.sv
module ser_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ser_tx_hold_reg.sv
module ser_tx_hold_reg #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              xfer,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  logic              full_d;
  logic              data_en;

  always_comb begin
    full_d  = full;
    data_en = 1'b0;
    if (!active) begin
      full_d = 1'b0;
    end else if (wr_valid) begin
      full_d  = 1'b1;
      data_en = 1'b1;
    end else if (xfer) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (data_en) word <= wr_word;
  end
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            baud_tick,
  input  logic            xfer,
  input  logic [DATA_W:0] hold_word,
  input  logic            nine_bit_mode,
  output logic            take,
  output logic            line,
  output logic            idle
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

  tx_state_e       state_q, state_d;
  logic [DATA_W:0] shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            nine_q, nine_d;
  logic            line_q, line_d;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = nine_q ? LAST9 : LAST8;
  assign take = active && ((state_q == ST_IDLE) ||
                           ((state_q == ST_STOP) && baud_tick));

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    nine_d  = nine_q;
    line_d  = line_q;
    if (!active) begin
      state_d = ST_IDLE;
      line_d  = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          line_d = 1'b1;
          if (xfer) begin
            shreg_d = hold_word;
            nine_d  = nine_bit_mode;
            state_d = ST_PEND;
          end
        end
        ST_PEND: begin
          if (baud_tick) begin
            line_d  = 1'b0;
            state_d = ST_START;
          end
        end
        ST_START: begin
          if (baud_tick) begin
            line_d  = shreg_q[0];
            shreg_d = shreg_q >> 1;
            cnt_d   = '0;
            state_d = ST_DATA;
          end
        end
        ST_DATA: begin
          if (baud_tick) begin
            if (cnt_q == last_idx) begin
              line_d  = 1'b1;
              state_d = ST_STOP;
            end else begin
              line_d  = shreg_q[0];
              shreg_d = shreg_q >> 1;
              cnt_d   = cnt_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (baud_tick) begin
            if (xfer) begin
              shreg_d = hold_word;
              nine_d  = nine_bit_mode;
              line_d  = 1'b0;
              state_d = ST_START;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          line_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      nine_q  <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      nine_q  <= nine_d;
      line_q  <= line_d;
    end
  end

  assign line = line_q;
  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              nine_bit_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              hold_empty,
  output logic              shift_empty
);
  localparam int WORD_W = DATA_W + 1;

  logic              rst_n_int;
  logic              active;
  logic              take;
  logic              xfer;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic              sh_idle;
  logic              sh_line;

  ser_tx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign active = port_en && tx_en;
  assign xfer   = take && hold_full;

  ser_tx_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active   (active),
    .wr_valid (wr_valid),
    .wr_word  ({wr_bit9, wr_data}),
    .xfer     (xfer),
    .full     (hold_full),
    .word     (hold_word)
  );

  ser_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .active        (active),
    .baud_tick     (baud_tick),
    .xfer          (xfer),
    .hold_word     (hold_word),
    .nine_bit_mode (nine_bit_mode),
    .take          (take),
    .line          (sh_line),
    .idle          (sh_idle)
  );

  assign tx_line     = sh_line;
  assign tx_oe       = port_en;
  assign hold_empty  = !hold_full;
  assign shift_empty = sh_idle;
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_en,
  input logic baud_tick,
  input logic wr_valid,
  input logic tx_line,
  input logic hold_empty,
  input logic shift_empty
);
  // R2
  write_fills_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && port_en && tx_en) |=> !hold_empty);

  // R2
  hold_moves_to_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_empty) && $past(port_en && tx_en)) |-> !shift_empty);

  // R3
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_en && tx_en) && (tx_line != $past(tx_line))) |-> $past(baud_tick));

  // R6
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx_line);

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && tx_en) |=> (tx_line && hold_empty && shift_empty));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .port_en     (port_en),
  .tx_en       (tx_en),
  .baud_tick   (baud_tick),
  .wr_valid    (wr_valid),
  .tx_line     (tx_line),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty)
);

// File: tb/ser_tx_dbuf_test.sv
module ser_tx_dbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int DATA_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              port_en, tx_en, baud_tick, nine_bit_mode, wr_valid, wr_bit9;
  logic [DATA_W-1:0] wr_data;
  logic              tx_line, tx_oe, hold_empty, shift_empty;

  int checks = 0;
  int fails  = 0;
  int frames_done = 0;
  bit mon_on = 0;
  bit gap_chk = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_tx_dbuf #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
    .baud_tick(baud_tick), .nine_bit_mode(nine_bit_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .tx_line(tx_line), .tx_oe(tx_oe), .hold_empty(hold_empty),
    .shift_empty(shift_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // tick generator and line decoder
  int tick_cnt = 0;
  int dstate = 0;
  int didx = 0;
  int idle_run = 0;
  bit had_frame = 0;
  logic [DATA_W:0] acc;
  initial baud_tick = 1'b0;

  always @(negedge clk) begin
    if (!mon_on) begin
      dstate = 0; idle_run = 0; had_frame = 0;
    end else if (baud_tick) begin
      if (!gap_chk) had_frame = 0;
      case (dstate)
        0: if (tx_line == 1'b0) begin
             // R5: no idle bit between streamed frames
             if (gap_chk && had_frame)
               check(idle_run == 0, "R5", "idle bits between frames", idle_run, 0);
             dstate = 1; didx = 0; acc = '0;
           end else idle_run++;
        1: begin
             acc[didx] = tx_line;
             didx++;
             if (didx == (nine_bit_mode ? DATA_W + 1 : DATA_W)) dstate = 2;
           end
        default: begin
             // R3: stop bit high after the data field
             check(tx_line == 1'b1, "R3", "stop bit", tx_line, 1);
             if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected frame", acc, 0);
             end else begin
               int e;
               e = exp_q.pop_front();
               if (!nine_bit_mode) e = e & ((1 << DATA_W) - 1);
               // R3 R4: data bits LSB first, ninth bit when selected
               check(acc == e, nine_bit_mode ? "R4" : "R3", "frame data", acc, e);
             end
             frames_done++;
             had_frame = 1; idle_run = 0; dstate = 0;
           end
      endcase
    end
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
    baud_tick = (tick_cnt == TICK_DIV - 1);
  end

  task automatic put_word(input int w, input bit b9);
    wr_valid = 1'b1; wr_data = w[DATA_W-1:0]; wr_bit9 = b9;
    exp_q.push_back({b9, w[DATA_W-1:0]});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_hold_empty();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!(hold_empty && shift_empty)) @(negedge clk);
  endtask

  task automatic sweep(input bit nine);
    nine_bit_mode = nine;
    gap_chk = 1;
    for (int i = 0; i < 256; i++) begin
      wait_hold_empty();
      put_word(i, nine ? ^i[7:0] : i[0]);
    end
    wait_idle();
    repeat (2 * TICK_DIV) @(negedge clk);
    gap_chk = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; port_en = 1'b0; tx_en = 1'b0; nine_bit_mode = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_bit9 = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
    check(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
    check(shift_empty == 1'b1, "R1", "shift_empty after reset", shift_empty, 1);
    check(tx_oe == 1'b0, "R1", "tx_oe with port off", tx_oe, 0);

    // R7 port on, transmitter off
    port_en = 1'b1;
    @(negedge clk);
    check(tx_oe == 1'b1, "R7", "tx_oe with tx_en low", tx_oe, 1);
    check(tx_line == 1'b1, "R7", "line with tx_en low", tx_line, 1);

    // R9 writes ignored while disabled
    wr_valid = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    check(hold_empty == 1'b1, "R9", "hold_empty after write, tx off", hold_empty, 1);
    check(shift_empty == 1'b1, "R9", "shift_empty after write, tx off", shift_empty, 1);
    port_en = 1'b0; tx_en = 1'b1;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    check(hold_empty == 1'b1, "R9", "hold_empty after write, port off", hold_empty, 1);
    check(tx_line == 1'b1, "R9", "line after write, port off", tx_line, 1);

    // R2 single word timing
    port_en = 1'b1;
    mon_on = 1;
    @(negedge clk);
    put_word(8'hA5, 1'b0);
    check(hold_empty == 1'b0, "R2", "hold_empty after write", hold_empty, 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R2", "hold_empty after transfer", hold_empty, 1);
    check(shift_empty == 1'b0, "R2", "shift_empty after transfer", shift_empty, 0);
    check(tx_line == 1'b1, "R3", "line before first tick", tx_line, 1);
    while (!shift_empty) @(negedge clk);
    // R6 flag returns only after the whole frame
    check(frames_done == 1, "R6", "frames done when shifter empty", frames_done, 1);
    check(tx_line == 1'b1, "R6", "line when shifter empty", tx_line, 1);
    repeat (2 * TICK_DIV) @(negedge clk);

    // R3 R5 eight-bit exhaustive stream, R4 nine-bit exhaustive stream
    sweep(1'b0);
    sweep(1'b1);
    check(frames_done == 513, "R5", "frames after sweeps", frames_done, 513);

    // R8 abort mid frame with a word held
    nine_bit_mode = 1'b0;
    put_word(8'hF0, 1'b0);
    wait_hold_empty();
    put_word(8'h0F, 1'b0);
    repeat (5 * TICK_DIV) @(negedge clk);
    check(hold_empty == 1'b0, "R8", "word held before abort", hold_empty, 0);
    mon_on = 0;
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(tx_line == 1'b1, "R8", "line after abort", tx_line, 1);
    check(hold_empty == 1'b1, "R8", "hold_empty after abort", hold_empty, 1);
    check(shift_empty == 1'b1, "R8", "shift_empty after abort", shift_empty, 1);
    exp_q.delete();
    repeat (3 * TICK_DIV) @(negedge clk);
    check(tx_line == 1'b1, "R7", "line held high while tx off", tx_line, 1);
    check(tx_oe == 1'b1, "R7", "tx_oe while tx off", tx_oe, 1);

    // recovery after abort
    tx_en = 1'b1;
    @(negedge clk);
    mon_on = 1;
    @(negedge clk);
    put_word(8'h5A, 1'b1);
    wait_idle();
    repeat (2 * TICK_DIV) @(negedge clk);
    check(exp_q.size() == 0, "R3", "words left unsent", exp_q.size(), 0);
    check(frames_done == 514, "R8", "frames after recovery", frames_done, 514);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule